// File: doc/BRIEF.md
# USB Endpoint Control Register

This block holds the control and status state of one endpoint of a USB device controller. Software reaches it through a single 32-bit register: it writes command bits and reads back the state. The protocol engine feeds it single-cycle event pulses. The state covers the endpoint enable, the endpoint NAK, STALL, the active flag, the data PID and the maximum packet size. From that state the block tells the protocol engine which handshake to return on the next token (ACK, NAK or STALL) and which data PID to use.

Software and hardware both change the same bits. Software acts through set-only and clear-only strobe bits. Hardware clears or sets bits on its own when protocol events occur. Whenever both act on a bit in the same cycle, a fixed priority decides. The parameter `IS_EP0` selects the variant:

- With `IS_EP0 = 1` the block serves control endpoint 0. This endpoint is always active.
- With `IS_EP0 = 0` it serves an interrupt or bulk endpoint, whose active flag is under software control and is dropped on bus reset.

Top module: `usb_ep_ctrl`

## Requirements
- R1: The enable bit (bit 31) is set by writing 1, and writing 0 to it has no effect. It is cleared by a setup-done, endpoint-disabled or transfer-complete event pulse. If such an event coincides with a write of 1, the clear wins.
- R2: Bit 30 (disable) and the strobe bits 29, 28, 27 and 26 always read 0. Writing 1 to bit 30 leaves the enable bit unchanged.
- R3: Writing 1 to bit 27 sets the endpoint NAK state. Writing 1 to bit 26 clears it. The NAK state reads back on bit 17.
- R4: A transfer-complete pulse sets the NAK state. A SETUP-packet-received pulse also sets it.
- R5: The STALL bit (bit 21) is set by writing 1, and writing 0 to it has no effect. A SETUP-token pulse clears it, and the pulse wins over a write of 1 in the same cycle.
- R6: The handshake output is encoded as 00 = ACK, 01 = NAK and 10 = STALL. While STALL is set the handshake is STALL, whatever the endpoint NAK or the global OUT NAK input holds.
- R7: The active bit (bit 15) is read/write when `IS_EP0 = 0`, and a USB-reset pulse clears it with priority over a write. When `IS_EP0 = 1` it always reads 1, and neither writes nor USB reset change it.
- R8: If any NAK-setting source (the bit 27 write, transfer complete or SETUP packet) coincides with a bit 26 clear-NAK write, the NAK state ends up set.
- R9: The data PID (bit 16, 0 = DATA0, 1 = DATA1) is loaded by writing 1 to bit 28 (DATA0) or to bit 29 (DATA1). If both are written together, DATA1 is loaded.
- R10: A transaction-done pulse toggles the data PID. A simultaneous bit 28 or bit 29 load takes precedence over the toggle.
- R11: Without STALL, the handshake is NAK when the NAK state is set, when the global OUT NAK input is high, when the endpoint is not enabled or when it is not active. Otherwise it is ACK.
- R12: The maximum packet size is read/write in bits 10 to 0 and is loaded on every write. Bits 14 to 11 read 0.
- R13: After reset the register reads 0, except the active bit, which equals `IS_EP0`. The handshake after reset is NAK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Software register write strobe |
| wrData | input | 32 | Software write data |
| rdData | output | 32 | Register read value |
| evUsbReset | input | 1 | USB bus reset detected (pulse) |
| evSetupToken | input | 1 | SETUP token received on this endpoint (pulse) |
| evSetupPkt | input | 1 | SETUP data packet received (pulse) |
| evXferDone | input | 1 | Transfer complete (pulse) |
| evEpDisabled | input | 1 | Endpoint disabled (pulse) |
| evSetupDone | input | 1 | SETUP stage done (pulse) |
| evTxnAck | input | 1 | Data packet acknowledged (pulse) |
| globalOutNak | input | 1 | Global OUT NAK in force |
| handshake | output | 2 | Handshake for next token: 00 ACK, 01 NAK, 10 STALL |
| dataPid | output | 1 | Current data PID, 0 = DATA0, 1 = DATA1 |

## Verification
Every write or event pulse lands in the register state on the clock edge where it is presented. Both `rdData` and `dataPid` show the new value directly after that edge. `handshake` follows that state in the same cycle, but it follows `globalOutNak` combinationally, with no delay at all. The bench therefore drives each vector on a falling edge and compares both outputs at the next falling edge. At that point exactly one rising edge has passed and the global NAK input is still the value of that vector. The concurrent properties use the same one-edge spacing: each trigger is followed by a check of the read value in the next cycle.

// File: rtl/usb_ep_pkg.sv
package usb_ep_pkg;

  localparam int REG_W   = 32;
  localparam int MPS_W   = 11;
  localparam int B_EN    = 31;
  localparam int B_DIS   = 30;
  localparam int B_SD1   = 29;
  localparam int B_SD0   = 28;
  localparam int B_SNAK  = 27;
  localparam int B_CNAK  = 26;
  localparam int B_STALL = 21;
  localparam int B_NAKST = 17;
  localparam int B_PID   = 16;
  localparam int B_ACT   = 15;

  typedef enum logic [1:0] {
    HS_ACK   = 2'b00,
    HS_NAK   = 2'b01,
    HS_STALL = 2'b10
  } hs_e;

  typedef struct packed {
    logic setEn;
    logic clrEn;
    logic setNak;
    logic clrNak;
    logic setStall;
    logic clrStall;
    logic wrAct;
    logic actVal;
    logic clrAct;
    logic loadPid;
    logic pidVal;
    logic togglePid;
    logic loadMps;
  } ep_strb_t;

endpackage

// File: rtl/usb_ep_ctrl_dec.sv
module usb_ep_ctrl_dec
  import usb_ep_pkg::*;
#(
  parameter bit IS_EP0 = 1'b0
) (
  input  logic     wrEn,
  input  logic     wrEnBit,
  input  logic     wrStallBit,
  input  logic     wrSetNakBit,
  input  logic     wrClrNakBit,
  input  logic     wrSd0Bit,
  input  logic     wrSd1Bit,
  input  logic     wrActBit,
  input  logic     evUsbReset,
  input  logic     evSetupToken,
  input  logic     evSetupPkt,
  input  logic     evXferDone,
  input  logic     evEpDisabled,
  input  logic     evSetupDone,
  input  logic     evTxnAck,
  output ep_strb_t strb
);

  logic hwEnClr;
  logic nakSetAny;
  logic pidLoad;

  always_comb begin
    hwEnClr   = evSetupDone | evEpDisabled | evXferDone;
    nakSetAny = (wrEn & wrSetNakBit) | evXferDone | evSetupPkt;
    pidLoad   = wrEn & (wrSd0Bit | wrSd1Bit);

    strb           = '0;
    strb.clrEn     = hwEnClr;
    strb.setEn     = wrEn & wrEnBit & ~hwEnClr;
    strb.setNak    = nakSetAny;
    strb.clrNak    = wrEn & wrClrNakBit & ~nakSetAny;
    strb.clrStall  = evSetupToken;
    strb.setStall  = wrEn & wrStallBit & ~evSetupToken;
    strb.clrAct    = evUsbReset & ~IS_EP0;
    strb.wrAct     = wrEn & ~strb.clrAct & ~IS_EP0;
    strb.actVal    = wrActBit;
    strb.loadPid   = pidLoad;
    strb.pidVal    = wrSd1Bit;
    strb.togglePid = evTxnAck & ~pidLoad;
    strb.loadMps   = wrEn;
  end

endmodule

// File: rtl/usb_ep_ctrl_dp.sv
module usb_ep_ctrl_dp
  import usb_ep_pkg::*;
#(
  parameter bit IS_EP0 = 1'b0,
  parameter int MPS_BITS = MPS_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  ep_strb_t            strb,
  input  logic [MPS_BITS-1:0] wrMps,
  input  logic                globalOutNak,
  output logic [REG_W-1:0]    rdData,
  output logic [1:0]          handshake,
  output logic                dataPid
);

  logic                enQ;
  logic                nakQ;
  logic                stallQ;
  logic                pidQ;
  logic                actQ;
  logic [MPS_BITS-1:0] mpsQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enQ    <= 1'b0;
      nakQ   <= 1'b0;
      stallQ <= 1'b0;
      pidQ   <= 1'b0;
      mpsQ   <= '0;
    end else begin
      if (strb.clrEn)         enQ <= 1'b0;
      else if (strb.setEn)    enQ <= 1'b1;
      if (strb.setNak)        nakQ <= 1'b1;
      else if (strb.clrNak)   nakQ <= 1'b0;
      if (strb.clrStall)      stallQ <= 1'b0;
      else if (strb.setStall) stallQ <= 1'b1;
      if (strb.loadPid)        pidQ <= strb.pidVal;
      else if (strb.togglePid) pidQ <= ~pidQ;
      if (strb.loadMps)       mpsQ <= wrMps;
    end
  end

  generate
    if (IS_EP0) begin : g_ep0_act
      logic unusedActStrb;
      assign unusedActStrb = ^{strb.wrAct, strb.actVal, strb.clrAct};
      assign actQ = 1'b1;
    end else begin : g_gen_act
      logic actR;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)            actR <= 1'b0;
        else if (strb.clrAct) actR <= 1'b0;
        else if (strb.wrAct)  actR <= strb.actVal;
      end
      assign actQ = actR;
    end
  endgenerate

  always_comb begin
    rdData          = '0;
    rdData[B_EN]    = enQ;
    rdData[B_STALL] = stallQ;
    rdData[B_NAKST] = nakQ;
    rdData[B_PID]   = pidQ;
    rdData[B_ACT]   = actQ;
    rdData[MPS_BITS-1:0] = mpsQ;
  end

  always_comb begin
    if (stallQ)
      handshake = HS_STALL;
    else if (nakQ || globalOutNak || !enQ || !actQ)
      handshake = HS_NAK;
    else
      handshake = HS_ACK;
  end

  assign dataPid = pidQ;

endmodule

// File: rtl/usb_ep_ctrl.sv
module usb_ep_ctrl
  import usb_ep_pkg::*;
#(
  parameter bit IS_EP0 = 1'b0
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [31:0] wrData,
  output logic [31:0] rdData,
  input  logic        evUsbReset,
  input  logic        evSetupToken,
  input  logic        evSetupPkt,
  input  logic        evXferDone,
  input  logic        evEpDisabled,
  input  logic        evSetupDone,
  input  logic        evTxnAck,
  input  logic        globalOutNak,
  output logic [1:0]  handshake,
  output logic        dataPid
);

  ep_strb_t strb;
  logic     unusedWrBits;

  assign unusedWrBits = ^{wrData[B_DIS], wrData[25:22], wrData[20:16], wrData[14:MPS_W]};

  usb_ep_ctrl_dec #(.IS_EP0(IS_EP0)) u_dec (
    .wrEn         (wrEn),
    .wrEnBit      (wrData[B_EN]),
    .wrStallBit   (wrData[B_STALL]),
    .wrSetNakBit  (wrData[B_SNAK]),
    .wrClrNakBit  (wrData[B_CNAK]),
    .wrSd0Bit     (wrData[B_SD0]),
    .wrSd1Bit     (wrData[B_SD1]),
    .wrActBit     (wrData[B_ACT]),
    .evUsbReset   (evUsbReset),
    .evSetupToken (evSetupToken),
    .evSetupPkt   (evSetupPkt),
    .evXferDone   (evXferDone),
    .evEpDisabled (evEpDisabled),
    .evSetupDone  (evSetupDone),
    .evTxnAck     (evTxnAck),
    .strb         (strb)
  );

  usb_ep_ctrl_dp #(.IS_EP0(IS_EP0), .MPS_BITS(MPS_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .wrMps        (wrData[MPS_W-1:0]),
    .globalOutNak (globalOutNak),
    .rdData       (rdData),
    .handshake    (handshake),
    .dataPid      (dataPid)
  );

endmodule

// File: rtl/usb_ep_ctrl_chk.sv
module usb_ep_ctrl_chk
  import usb_ep_pkg::*;
#(
  parameter bit IS_EP0 = 1'b0
) (
  input logic        clk,
  input logic        rstN,
  input logic        wrEn,
  input logic [31:0] wrData,
  input logic [31:0] rdData,
  input logic        evUsbReset,
  input logic        evSetupToken,
  input logic        evSetupPkt,
  input logic        evXferDone,
  input logic        evEpDisabled,
  input logic        evSetupDone,
  input logic        evTxnAck,
  input logic [1:0]  handshake
);

  AST_EN_HW_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (evXferDone || evEpDisabled || evSetupDone) |=> !rdData[B_EN]); // R1

  AST_NAK_BY_EVENT: assert property (@(posedge clk) disable iff (!rstN)
    (evXferDone || evSetupPkt) |=> rdData[B_NAKST]); // R4

  AST_SETUP_CLEARS_STALL: assert property (@(posedge clk) disable iff (!rstN)
    evSetupToken |=> !rdData[B_STALL]); // R5

  AST_STALL_OVER_NAK: assert property (@(posedge clk) disable iff (!rstN)
    rdData[B_STALL] |-> (handshake == HS_STALL)); // R6

  AST_ACT_BUS_RESET: assert property (@(posedge clk) disable iff (!rstN)
    (evUsbReset && !IS_EP0) |=> !rdData[B_ACT]); // R7

  AST_EP0_ALWAYS_ACT: assert property (@(posedge clk) disable iff (!rstN)
    IS_EP0 |-> rdData[B_ACT]); // R7

  AST_NAK_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrData[B_SNAK] && wrData[B_CNAK]) |=> rdData[B_NAKST]); // R8

  AST_PID_TOGGLE: assert property (@(posedge clk) disable iff (!rstN)
    (evTxnAck && !(wrEn && (wrData[B_SD0] || wrData[B_SD1])))
      |=> (rdData[B_PID] != $past(rdData[B_PID]))); // R10

  AST_IDLE_NAK: assert property (@(posedge clk) disable iff (!rstN)
    (!rdData[B_STALL] && !rdData[B_EN]) |-> (handshake == HS_NAK)); // R11

endmodule

bind usb_ep_ctrl usb_ep_ctrl_chk #(.IS_EP0(IS_EP0)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .wrEn         (wrEn),
  .wrData       (wrData),
  .rdData       (rdData),
  .evUsbReset   (evUsbReset),
  .evSetupToken (evSetupToken),
  .evSetupPkt   (evSetupPkt),
  .evXferDone   (evXferDone),
  .evEpDisabled (evEpDisabled),
  .evSetupDone  (evSetupDone),
  .evTxnAck     (evTxnAck),
  .handshake    (handshake)
);

// File: tb/usb_ep_ctrl_tb.sv
`timescale 1ns/1ps
module usb_ep_ctrl_tb;

  // event vector order: [6] usbReset [5] setupToken [4] setupPkt
  // [3] xferDone [2] epDisabled [1] setupDone [0] txnAck
  typedef struct packed {
    logic [31:0] tag;
    logic        wr;
    logic [31:0] data;
    logic [6:0]  ev;
    logic        gNak;
    logic [31:0] expRd;
    logic [1:0]  expHs;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{"R12 ", 1'b1, 32'h80008040, 7'h00, 1'b0, 32'h80008040, 2'd0},
    '{"R3  ", 1'b1, 32'h88008040, 7'h00, 1'b0, 32'h80028040, 2'd1},
    '{"R3  ", 1'b1, 32'h84008040, 7'h00, 1'b0, 32'h80008040, 2'd0},
    '{"R11 ", 1'b0, 32'h00000000, 7'h00, 1'b1, 32'h80008040, 2'd1},
    '{"R6  ", 1'b1, 32'h80208040, 7'h00, 1'b1, 32'h80208040, 2'd2},
    '{"R5  ", 1'b1, 32'h88008040, 7'h00, 1'b0, 32'h80228040, 2'd2},
    '{"R5  ", 1'b0, 32'h00000000, 7'h20, 1'b0, 32'h80028040, 2'd1},
    '{"R3  ", 1'b1, 32'h84008040, 7'h00, 1'b0, 32'h80008040, 2'd0},
    '{"R4  ", 1'b0, 32'h00000000, 7'h08, 1'b0, 32'h00028040, 2'd1},
    '{"R8  ", 1'b1, 32'h84008040, 7'h10, 1'b0, 32'h80028040, 2'd1},
    '{"R11 ", 1'b1, 32'h84008040, 7'h00, 1'b0, 32'h80008040, 2'd0},
    '{"R9  ", 1'b1, 32'hA0008040, 7'h00, 1'b0, 32'h80018040, 2'd0},
    '{"R10 ", 1'b0, 32'h00000000, 7'h01, 1'b0, 32'h80008040, 2'd0},
    '{"R10 ", 1'b0, 32'h00000000, 7'h01, 1'b0, 32'h80018040, 2'd0},
    '{"R10 ", 1'b1, 32'h90008040, 7'h01, 1'b0, 32'h80008040, 2'd0},
    '{"R9  ", 1'b1, 32'hB0008040, 7'h00, 1'b0, 32'h80018040, 2'd0},
    '{"R12 ", 1'b1, 32'h8000FFFF, 7'h00, 1'b0, 32'h800187FF, 2'd0},
    '{"R2  ", 1'b1, 32'h40008040, 7'h00, 1'b0, 32'h80018040, 2'd0},
    '{"R1  ", 1'b0, 32'h00000000, 7'h04, 1'b0, 32'h00018040, 2'd1},
    '{"R1  ", 1'b1, 32'h80008040, 7'h02, 1'b0, 32'h00018040, 2'd1},
    '{"R7  ", 1'b0, 32'h00000000, 7'h40, 1'b0, 32'h00010040, 2'd1},
    '{"R7  ", 1'b1, 32'h80008040, 7'h40, 1'b0, 32'h80010040, 2'd1}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [6:0]  ev = '0;
  logic        globalOutNak = 1'b0;
  logic [31:0] rdData, rdEp0;
  logic [1:0]  handshake, hsEp0;
  logic        dataPid, pidEp0;

  int checkCnt = 0;
  int failCnt  = 0;

  always #2.5 clk = ~clk;

  usb_ep_ctrl #(.IS_EP0(1'b0)) u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .evUsbReset(ev[6]), .evSetupToken(ev[5]), .evSetupPkt(ev[4]),
    .evXferDone(ev[3]), .evEpDisabled(ev[2]), .evSetupDone(ev[1]),
    .evTxnAck(ev[0]), .globalOutNak(globalOutNak),
    .handshake(handshake), .dataPid(dataPid)
  );

  usb_ep_ctrl #(.IS_EP0(1'b1)) u_ep0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdEp0),
    .evUsbReset(ev[6]), .evSetupToken(ev[5]), .evSetupPkt(ev[4]),
    .evXferDone(ev[3]), .evEpDisabled(ev[2]), .evSetupDone(ev[1]),
    .evTxnAck(ev[0]), .globalOutNak(globalOutNak),
    .handshake(hsEp0), .dataPid(pidEp0)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R13 reset state
    check("R13 rd", rdData, 32'h0);
    check("R13 hs", {30'd0, handshake}, 32'd1);
    check("R13 ep0 rd", rdEp0, 32'h00008000);
    check("R13 ep0 hs", {30'd0, hsEp0}, 32'd1);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      wrEn = VECS[i].wr;
      wrData = VECS[i].data;
      ev = VECS[i].ev;
      globalOutNak = VECS[i].gNak;
      @(negedge clk);
      check($sformatf("%s vec %0d rd", VECS[i].tag, i), rdData, VECS[i].expRd);
      check($sformatf("%s vec %0d hs", VECS[i].tag, i), {30'd0, handshake},
            {30'd0, VECS[i].expHs});
      check($sformatf("%s vec %0d pid", VECS[i].tag, i), {31'd0, dataPid},
            {31'd0, VECS[i].expRd[16]});
    end
    wrEn = 1'b0; ev = '0; globalOutNak = 1'b0;

    // R7: endpoint 0 stays active through bus resets and writes of 0
    check("R7 ep0 active", {31'd0, rdEp0[15]}, 32'd1);
    wrEn = 1'b1; wrData = 32'h40000040;
    @(negedge clk);
    wrEn = 1'b0;
    check("R7 ep0 active after write 0", {31'd0, rdEp0[15]}, 32'd1);
    // R2: disable bit reads 0 and enable unchanged on endpoint 0
    check("R2 ep0 dis bit", {31'd0, rdEp0[30]}, 32'd0);
    check("R2 ep0 enable kept", {31'd0, rdEp0[31]}, 32'd1);
    check("R11 ep0 ack", {30'd0, hsEp0}, 32'd0);

    // R6: stall beats global NAK on endpoint 0
    wrEn = 1'b1; wrData = 32'h80200040; globalOutNak = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
    check("R6 ep0 stall", {30'd0, hsEp0}, 32'd2);
    // R5: setup token together with stall write clears stall
    wrEn = 1'b1; wrData = 32'h80200040; ev = 7'h20;
    @(negedge clk);
    wrEn = 1'b0; ev = '0; globalOutNak = 1'b0;
    check("R5 token wins", {31'd0, rdEp0[21]}, 32'd0);

    // R13: reset mid-run returns reset values
    rstN = 1'b0;
    @(negedge clk);
    check("R13 rd after reset", rdData, 32'h0);
    check("R13 ep0 rd after reset", rdEp0, 32'h00008000);
    rstN = 1'b1;
    @(negedge clk);

    summary();
    $finish;
  end

endmodule